// File: doc/BRIEF.md
# RS-485 Auto-Direction UART Transmitter

This block is a UART transmitter with a small transmit queue. Its main job is to drive the enable of a half-duplex RS-485 line driver through an active-low RTS output. The host writes bytes with a single-cycle strobe. The transmitter shifts each byte out as a fixed 8N1 frame, timed by a single-cycle baud tick enable that is generated elsewhere.

The RTS output can come from three sources. Automatic direction control has the highest priority. In that mode RTS is asserted while the transmitter has work, meaning the queue holds bytes or a frame is on the wire. RTS is released once the stop bit of the final queued character has finished. In this mode only, an invert input reverses the polarity. When automatic mode is off, RTS follows either the request from the hardware flow-control logic or the host's manual RTS bit, with flow control taking priority over the manual bit.

A write arriving while the queue is full is dropped, and a one-cycle overflow pulse is produced.

Top module: `rs485_dir_tx`

## Requirements
- R1: RTS source priority is fixed: `auto_dir_en` overrides `hwfc_en` and both request inputs; with automatic mode off, `hwfc_en` selects `rts_flow_req` over `rts_manual`.
- R2: With automatic mode off, `rts_n` is the inverse of the selected request: `~rts_flow_req` when `hwfc_en` is 1, otherwise `~rts_manual` (a request of 1 drives `rts_n` low).
- R3: In automatic mode without inversion, `rts_n` is low in the first cycle after the clock edge that accepts a write into an empty, idle transmitter.
- R4: In automatic mode without inversion, `rts_n` stays low continuously while the queue is non-empty or a frame is being shifted, including across back-to-back characters.
- R5: In automatic mode without inversion, `rts_n` returns high in the cycle after the baud tick that ends the stop bit of a character, if no byte is queued at that point. A write accepted on that same edge keeps `rts_n` low.
- R6: `rts_invert` reverses `rts_n` only while `auto_dir_en` is 1: high while work is pending, low when idle. With automatic mode off it has no effect on `rts_n`.
- R7: Each frame is one start bit (0), 8 data bits LSB first, and one stop bit (1). Each bit lasts exactly one baud tick period, and a frame starts only on a baud tick. `txd` idles at 1 and changes only on a clock edge at which `baud_tick` is 1.
- R8: The queue holds 16 bytes and sends them in write order. A write while 16 bytes are held is dropped, even if a byte leaves in the same cycle, and `overflow` is 1 for exactly the following cycle.
- R9: After reset, `txd` is 1, `overflow` is 0 and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe into the transmit queue |
| wr_data | input | 8 | Byte to queue |
| baud_tick | input | 1 | Single-cycle bit-time enable |
| auto_dir_en | input | 1 | Automatic direction control of RTS |
| rts_invert | input | 1 | Reverse RTS polarity in automatic mode |
| hwfc_en | input | 1 | Hardware flow control selects the RTS source |
| rts_manual | input | 1 | Host RTS request bit (1 = assert) |
| rts_flow_req | input | 1 | Flow-control RTS request (1 = assert) |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Active-low RTS / driver enable |
| overflow | output | 1 | One-cycle pulse on a dropped write |

## Verification
The hardest case is a host write that lands on the same clock edge as the baud tick ending the stop bit of the last queued character. That edge both releases the shifter and fills the empty queue, so a release and a re-assertion of RTS coincide. The bench watches its own frame decoder and, during the stop-bit tick cycle, raises the write strobe so that both events share one edge. It then requires `rts_n` to stay asserted at every sample with no one-cycle gap. It also requires the late byte to follow as a clean frame of its own. A second pairing, a write to a full queue while the queue cannot drain, is judged by the overflow pulse and by the absence of the dropped byte from the decoded stream.

// File: rtl/rs485_tx_pkg.sv
package rs485_tx_pkg;
    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_phase_e;
endpackage

// File: rtl/tx_fifo.sv
module tx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full,
    output logic             overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty    = (q.cnt == '0);
    assign full     = (q.cnt == CW'(DEPTH));
    assign do_push  = push && !full;
    assign do_pop   = pop && !empty;
    assign dout     = mem[q.rd];
    assign overflow = q.ovf;

    always_comb begin
        d     = q;
        d.ovf = push && full;
        if (do_push) d.wr = ptr_inc(q.wr);
        if (do_pop)  d.rd = ptr_inc(q.rd);
        case ({do_push, do_pop})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[q.wr] <= din;
    end

    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH));
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> full);
    p_ovf_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !$past(push)) |-> 1'b0);
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import rs485_tx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 baud_tick,
    input  logic                 q_empty,
    input  logic [DATA_BITS-1:0] q_data,
    output logic                 q_pop,
    output logic                 txd,
    output logic                 busy
);
    localparam int BCW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    typedef struct packed {
        tx_phase_e            phase;
        logic [DATA_BITS-1:0] sh;
        logic [BCW-1:0]       idx;
    } sh_st_t;

    sh_st_t q, d;

    assign q_pop = baud_tick && !q_empty &&
                   (q.phase == TX_IDLE || q.phase == TX_STOP);
    assign busy  = (q.phase != TX_IDLE);

    always_comb begin
        case (q.phase)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = q.sh[0];
            default:  txd = 1'b1;
        endcase
    end

    always_comb begin
        d = q;
        if (baud_tick) begin
            case (q.phase)
                TX_IDLE: begin
                    if (q_pop) begin
                        d.phase = TX_START;
                        d.sh    = q_data;
                    end
                end
                TX_START: begin
                    d.phase = TX_DATA;
                    d.idx   = '0;
                end
                TX_DATA: begin
                    d.sh  = q.sh >> 1;
                    d.idx = q.idx + 1'b1;
                    if (q.idx == BCW'(DATA_BITS - 1)) d.phase = TX_STOP;
                end
                TX_STOP: begin
                    if (q_pop) begin
                        d.phase = TX_START;
                        d.sh    = q_data;
                    end else begin
                        d.phase = TX_IDLE;
                    end
                end
                default: d.phase = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{phase: TX_IDLE, sh: '0, idx: '0};
        else        q <= d;
    end

    p_txd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_tick |=> $stable(txd));
    p_start_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |=> (txd == 1'b0));
    p_pop_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q_pop |-> !q_empty);
endmodule

// File: rtl/rts_select.sv
module rts_select (
    input  logic auto_dir_en,
    input  logic rts_invert,
    input  logic hwfc_en,
    input  logic rts_manual,
    input  logic rts_flow_req,
    input  logic tx_active,
    output logic rts_n
);
    always_comb begin
        if (auto_dir_en)  rts_n = rts_invert ? tx_active : !tx_active;
        else if (hwfc_en) rts_n = !rts_flow_req;
        else              rts_n = !rts_manual;
    end
endmodule

// File: rtl/rs485_dir_tx.sv
module rs485_dir_tx #(
    parameter int FIFO_DEPTH = 16,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [DATA_BITS-1:0] wr_data,
    input  logic                 baud_tick,
    input  logic                 auto_dir_en,
    input  logic                 rts_invert,
    input  logic                 hwfc_en,
    input  logic                 rts_manual,
    input  logic                 rts_flow_req,
    output logic                 txd,
    output logic                 rts_n,
    output logic                 overflow
);
    logic [DATA_BITS-1:0] q_data;
    logic q_empty, q_full, q_pop, sh_busy, tx_active;

    tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_BITS)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .din(wr_data), .pop(q_pop),
        .dout(q_data), .empty(q_empty), .full(q_full), .overflow(overflow)
    );

    tx_shifter #(.DATA_BITS(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .q_empty(q_empty),
        .q_data(q_data), .q_pop(q_pop), .txd(txd), .busy(sh_busy)
    );

    assign tx_active = !q_empty || sh_busy;

    rts_select u_rts (
        .auto_dir_en(auto_dir_en), .rts_invert(rts_invert), .hwfc_en(hwfc_en),
        .rts_manual(rts_manual), .rts_flow_req(rts_flow_req),
        .tx_active(tx_active), .rts_n(rts_n)
    );

    p_auto_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dir_en && !rts_invert && !q_empty) |-> !rts_n);
    p_auto_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dir_en && !rts_invert && q_empty && !sh_busy) |-> rts_n);
    p_flow_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_dir_en && hwfc_en) |-> (rts_n == !rts_flow_req));
    p_manual_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_dir_en && !hwfc_en) |-> (rts_n == !rts_manual));
    p_invert_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dir_en && rts_invert && sh_busy) |-> rts_n);
    p_write_assert_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_dir_en && !rts_invert && wr_en && !q_full &&
         $stable(auto_dir_en) && $stable(rts_invert)) |=> !rts_n);
endmodule

// File: tb/rs485_dir_tx_test.sv
`timescale 1ns/1ps
module rs485_dir_tx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic baud_tick = 1'b0;
    logic auto_dir_en = 1'b0, rts_invert = 1'b0, hwfc_en = 1'b0;
    logic rts_manual = 1'b0, rts_flow_req = 1'b0;
    logic txd, rts_n, overflow;

    int checks = 0;
    int errors = 0;
    int pending = 0;
    int frames = 0;
    bit tick_en = 1'b1;
    bit rts_watch = 1'b0;
    bit in_frame = 1'b0;
    int bit_idx = 0;
    logic [7:0] rx_byte;
    logic [7:0] exp_q [$];
    int tick_cnt = 0;

    always #2.5 clk = ~clk;

    rs485_dir_tx uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .baud_tick(baud_tick), .auto_dir_en(auto_dir_en),
        .rts_invert(rts_invert), .hwfc_en(hwfc_en), .rts_manual(rts_manual),
        .rts_flow_req(rts_flow_req), .txd(txd), .rts_n(rts_n),
        .overflow(overflow)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // tick generator: one cycle in four, driven just after the clock edge
    always @(posedge clk) begin
        #1;
        tick_cnt  = (tick_cnt + 1) % 4;
        baud_tick = tick_en && (tick_cnt == 0);
    end

    // monitor: RTS follows pending work; frames decoded and scoreboarded
    always @(negedge clk) begin
        if (rst_n && rts_watch) begin
            automatic bit act = (pending > 0);
            automatic logic e = rts_invert ? act : !act;
            chk(rts_n == e, rts_invert ? "R6" : (act ? "R4" : "R5"),
                "rts_n vs pending work", rts_n, e);
        end
        if (rst_n && baud_tick) begin
            if (!in_frame) begin
                if (txd == 1'b0) begin
                    in_frame = 1'b1;
                    bit_idx  = 0;
                end
            end else if (bit_idx < 8) begin
                rx_byte[bit_idx] = txd;
                bit_idx++;
            end else begin
                chk(txd == 1'b1, "R7", "stop bit", txd, 1);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected frame", rx_byte, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    chk(rx_byte == e, "R8", "byte order/value", rx_byte, e);
                end
                frames++;
                pending--;
                in_frame = 1'b0;
            end
        end
    end

    task automatic write_byte(input logic [7:0] b, input bit accept);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = b;
        @(posedge clk); #1;
        wr_en = 1'b0;
        if (accept) begin
            pending++;
            exp_q.push_back(b);
        end
    endtask

    task automatic drain();
        while (pending > 0) @(posedge clk);
        repeat (8) @(posedge clk);
    endtask

    task automatic settle_chk(input logic e, input string req, input string what);
        @(posedge clk); #1;
        chk(rts_n == e, req, what, rts_n, e);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(txd == 1'b1, "R9", "txd after reset", txd, 1);
        chk(overflow == 1'b0, "R9", "overflow after reset", overflow, 0);
        chk(rts_n == 1'b1, "R2", "rts_n manual=0", rts_n, 1);

        rts_manual = 1'b1;
        settle_chk(1'b0, "R2", "manual request asserts");
        rts_invert = 1'b1;
        settle_chk(1'b0, "R6", "invert ignored in manual mode");
        hwfc_en = 1'b1; rts_flow_req = 1'b0;
        settle_chk(1'b1, "R1", "flow control over manual");
        rts_flow_req = 1'b1;
        settle_chk(1'b0, "R2", "flow request asserts");
        rts_flow_req = 1'b0;
        settle_chk(1'b1, "R6", "invert ignored in flow mode");
        rts_invert = 1'b0; rts_flow_req = 1'b1;
        auto_dir_en = 1'b1;
        settle_chk(1'b1, "R1", "auto idle over flow and manual");
        @(negedge clk); rts_watch = 1'b1;

        // single byte: assertion in the cycle after acceptance
        write_byte(8'hA5, 1'b1);
        chk(rts_n == 1'b0, "R3", "rts_n after write", rts_n, 0);
        drain();

        // back-to-back characters
        write_byte(8'h3C, 1'b1);
        write_byte(8'h01, 1'b1);
        write_byte(8'hFF, 1'b1);
        drain();

        // write on the same edge as the final stop-bit tick
        write_byte(8'h96, 1'b1);
        forever begin
            @(posedge clk); #2;
            if (baud_tick && in_frame && bit_idx == 8) break;
        end
        wr_en = 1'b1; wr_data = 8'h4B;
        @(posedge clk); #1;
        wr_en = 1'b0; pending++; exp_q.push_back(8'h4B);
        chk(rts_n == 1'b0, "R5", "write at stop tick keeps rts", rts_n, 0);
        drain();

        // inverted polarity in automatic mode
        @(negedge clk); rts_watch = 1'b0; rts_invert = 1'b1;
        @(negedge clk); rts_watch = 1'b1;
        write_byte(8'h5A, 1'b1);
        write_byte(8'h80, 1'b1);
        drain();
        chk(rts_n == 1'b0, "R6", "inverted idle level", rts_n, 0);
        @(negedge clk); rts_watch = 1'b0; rts_invert = 1'b0;
        @(negedge clk); rts_watch = 1'b1;

        // fill with the line frozen, then overflow
        tick_en = 1'b0;
        repeat (6) @(posedge clk);
        for (int i = 0; i < 16; i++) write_byte(8'(i * 17 + 3), 1'b1);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_data = 8'hEE;
        @(posedge clk); #1;
        wr_en = 1'b0;
        chk(overflow == 1'b1, "R8", "overflow pulse", overflow, 1);
        @(posedge clk); #1;
        chk(overflow == 1'b0, "R8", "overflow one cycle", overflow, 0);
        tick_en = 1'b1;
        drain();
        chk(exp_q.size() == 0, "R8", "all queued bytes sent", exp_q.size(), 0);
        chk(frames == 24, "R7", "frame count", frames, 24);
        chk(txd == 1'b1, "R7", "idle line", txd, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule